// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of hardware sources and from a small group of sources that only software can raise. Each source has a 4-bit priority held in a register. Every cycle the block picks the most urgent pending request and offers its 9-bit vector number to the processor. A current-priority level acts as a mask: only a request whose priority is strictly greater than that level is offered. Software can write the level directly to set a ceiling that stops tasks sharing a resource from preempting each other.

The interrupt output is a valid/ready pair carrying the vector. `irq_valid_o` and `irq_vector_o` are registered and are meaningful only while valid is high. These are interrupt semantics, not a lossless stream. Valid may fall, or the vector may change to a more urgent one, without a handshake whenever requests, priorities or the mask change. Holding `irq_ready_i` low simply leaves the request on offer. The handshake takes place at a rising edge where valid and ready are both high. Ready while valid is low is ignored.

On acknowledge, the block saves the current level on a last-in-first-out stack and raises the level to the priority of the granted source, so only a strictly higher request can preempt. A pulse on `eoi_i` pops the stack and restores the saved level. Registers are reached through a single-cycle write strobe and a combinational read path.

Top module: `pvic_top`

## Requirements
- R1: Hardware source i (bit i of `hw_req_i`) has vector i. Software source k has vector N_HW+k. The vector of the winning source appears on `irq_vector_o`.
- R2: The priority of source s is at address 4+s, in data bits [3:0]. It can be written and read back, and it resets to 0.
- R3: A source whose priority is 0 is never offered, whatever the state of its request.
- R4: The offered source has the highest priority among eligible pending sources. When several share that priority, the one with the lowest source index wins.
- R5: The current level is at address 0, in bits [3:0], and resets to 0. A request is offered only if its priority is strictly greater than the current level.
- R6: A write to address 1 sets software source k for each 1 in data bit k. A write to address 2 clears it. Zero bits in either write leave their sources unchanged. Reading address 1 returns the pending software bits.
- R7: Valid and vector change one clock edge after the requests, priorities or level that produced them. The edge of an acknowledge (valid and ready both high) drives valid low for the following cycle and loads the current level with the granted source's priority. Ready while valid is low changes nothing.
- R8: Each acknowledge pushes the previous level onto a LIFO that is DEPTH entries deep. Each `eoi_i` pops it and restores that level. An `eoi_i` with an empty stack is ignored. An acknowledge with a full stack still loads the new level, but the old level is dropped rather than saved.
- R9: While a routine is being served at level L, a pending request with priority above L is offered, and it can be acknowledged to nest a further level.
- R10: A request removed before acknowledge is not held. Valid falls on the edge after the request falls.
- R11: An acknowledge together with `eoi_i` on a non-empty stack loads the granted priority and leaves the stack unchanged. An acknowledge together with a write to address 0 loads the granted priority, and the write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hw_req_i | input | N_HW | Level-sensitive hardware requests |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| irq_valid_o | output | 1 | A vector is on offer |
| irq_vector_o | output | 9 | Vector number of the offered source |
| irq_ready_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End of service: restores the saved level |

## Verification
The bench builds the block with 12 hardware sources, 8 software sources and a stack only 4 entries deep. The shallow stack lets a nesting of five acknowledges reach the full-stack case in which a level is dropped, and the following pops then restore the surviving levels down to an empty-stack end-of-service. With only 20 sources, the random sequence, which mixes priority rewrites, level writes, acknowledges and end-of-service pulses, hits priority ties and level collisions on the same sources often. It is compared against a model held in the bench.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W      = 4;
  localparam int VEC_W       = 9;
  localparam int ADDR_CUR    = 0;
  localparam int ADDR_SW_SET = 1;
  localparam int ADDR_SW_CLR = 2;
  localparam int ADDR_PRIO0  = 4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [VEC_W-1:0]  vec_t;
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int N_HW   = 24,
  parameter int N_SW   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  prio_t                          cur_i,
  output logic [(N_HW+N_SW)*PRIO_W-1:0]  prio_flat_o,
  output logic [N_SW-1:0]                sw_pend_o,
  output logic                           cur_wr_o,
  output prio_t                          cur_wdata_o,
  output logic [DATA_W-1:0]              rdata_o
);
  localparam int N_SRC = N_HW + N_SW;
  localparam int IDX_W = $clog2(N_SRC);
  localparam int USE_W = (N_SW > PRIO_W) ? N_SW : PRIO_W;

  prio_t             prio_q [N_SRC];
  logic [N_SW-1:0]   pend_q;
  logic [ADDR_W-1:0] rel;
  logic              prio_sel;
  logic              set_hit, clr_hit;

  assign rel      = addr_i - ADDR_W'(ADDR_PRIO0);
  assign prio_sel = (addr_i >= ADDR_W'(ADDR_PRIO0)) && (rel < ADDR_W'(N_SRC));
  assign set_hit  = wr_i && (addr_i == ADDR_W'(ADDR_SW_SET));
  assign clr_hit  = wr_i && (addr_i == ADDR_W'(ADDR_SW_CLR));

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    always_ff @(posedge clk_i) begin
      if (!rst_ni)
        prio_q[g] <= '0;
      else if (wr_i && prio_sel && rel == ADDR_W'(g))
        prio_q[g] <= wdata_i[PRIO_W-1:0];
    end
    assign prio_flat_o[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)
      pend_q <= '0;
    else if (set_hit)
      pend_q <= pend_q | wdata_i[N_SW-1:0];
    else if (clr_hit)
      pend_q <= pend_q & ~wdata_i[N_SW-1:0];
  end

  assign sw_pend_o   = pend_q;
  assign cur_wr_o    = wr_i && (addr_i == ADDR_W'(ADDR_CUR));
  assign cur_wdata_o = wdata_i[PRIO_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CUR))
      rdata_o[PRIO_W-1:0] = cur_i;
    else if (addr_i == ADDR_W'(ADDR_SW_SET))
      rdata_o[N_SW-1:0] = pend_q;
    else if (prio_sel)
      rdata_o[PRIO_W-1:0] = prio_q[rel[IDX_W-1:0]];
  end

  if (DATA_W > USE_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^wdata_i[DATA_W-1:USE_W];
  end

  // R6: a clear write leaves none of its selected bits pending
  p_sw_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> (pend_q & $past(wdata_i[N_SW-1:0])) == '0);
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat_i,
  input  prio_t                   cur_i,
  output logic                    win_valid_o,
  output vec_t                    win_idx_o,
  output prio_t                   win_prio_o
);
  prio_t best_p;
  vec_t  best_i;

  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && prio_flat_i[i*PRIO_W +: PRIO_W] > cur_i &&
          prio_flat_i[i*PRIO_W +: PRIO_W] > best_p) begin
        best_p = prio_flat_i[i*PRIO_W +: PRIO_W];
        best_i = VEC_W'(i);
      end
    end
  end

  assign win_valid_o = (best_p != '0);
  assign win_idx_o   = best_i;
  assign win_prio_o  = best_p;
endmodule

// File: rtl/pvic_prio_stack.sv
module pvic_prio_stack
  import pvic_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  logic  pop_i,
  input  prio_t load_i,
  input  logic  wr_i,
  input  prio_t wr_prio_i,
  output prio_t cur_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  prio_t            cur_q;
  logic             full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (push_i && pop_i && !empty) begin
      cur_q <= load_i;
    end else if (push_i) begin
      cur_q <= load_i;
      if (!full) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      cur_q <= mem[cnt_q - 1'b1];
      cnt_q <= cnt_q - 1'b1;
    end else if (wr_i) begin
      cur_q <= wr_prio_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !(pop_i && !empty) && !full)
      mem[cnt_q] <= cur_q;
  end

  assign cur_o = cur_q;

  // R8: the stack never holds more than DEPTH levels
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R8: an end of service on an empty stack leaves the level alone
  p_empty_pop_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> $stable(cur_q));
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int N_HW   = 24,
  parameter int N_SW   = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HW-1:0]   hw_req_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  output logic [8:0]        irq_vector_o,
  input  logic              irq_ready_i,
  input  logic              eoi_i
);
  localparam int N_SRC = N_HW + N_SW;

  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SW-1:0]         sw_pend;
  logic                    cur_wr;
  prio_t                   cur_wdata, cur_w;
  logic                    win_valid;
  vec_t                    win_idx;
  prio_t                   win_prio;
  logic                    valid_q, ack;
  vec_t                    vec_q;
  prio_t                   prio_q;

  pvic_regs #(.N_HW(N_HW), .N_SW(N_SW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .cur_i(cur_w), .prio_flat_o(prio_flat), .sw_pend_o(sw_pend),
    .cur_wr_o(cur_wr), .cur_wdata_o(cur_wdata), .rdata_o(reg_rdata_o));

  pvic_arbiter #(.N_SRC(N_SRC)) arb_i (
    .req_i({sw_pend, hw_req_i}), .prio_flat_i(prio_flat), .cur_i(cur_w),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_prio_o(win_prio));

  assign ack = valid_q && irq_ready_i;

  pvic_prio_stack #(.DEPTH(DEPTH)) stack_i (
    .clk_i, .rst_ni, .push_i(ack), .pop_i(eoi_i), .load_i(prio_q),
    .wr_i(cur_wr), .wr_prio_i(cur_wdata), .cur_o(cur_w));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      prio_q  <= '0;
    end else begin
      valid_q <= win_valid && !ack;
      vec_q   <= win_idx;
      prio_q  <= win_prio;
    end
  end

  assign irq_valid_o  = valid_q;
  assign irq_vector_o = vec_q;

  // R1: an offered vector always names an existing source
  p_vec_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> vec_q < VEC_W'(N_SRC));
  // R3: nothing at priority zero is ever offered
  p_no_zero_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> prio_q != '0);
  // R5: an offer sits strictly above the level it was chosen against
  p_above_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> prio_q > $past(cur_w));
  // R7: the acknowledge edge withdraws the offer
  p_ack_clears_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !valid_q);
  // R7, R11: the granted priority becomes the current level
  p_ack_loads_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> cur_w == $past(prio_q));
endmodule

// File: tb/pvic_top_tb_top.sv
`timescale 1ns/1ps
module pvic_top_tb_top;
  localparam int N_HW = 12, N_SW = 8, N_SRC = 20, DEPTH = 4, ADDR_W = 8, DATA_W = 16;

  logic clk = 0, rst_n = 0;
  logic [N_HW-1:0] hw = '0;
  logic wr = 0, rdy = 0, eoi = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic vld;
  logic [8:0] vec;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_prio[N_SRC];
  int m_sw = 0, m_cur = 0, m_cnt = 0;
  int m_stk[DEPTH];

  pvic_top #(.N_HW(N_HW), .N_SW(N_SW), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_valid_o(vld), .irq_vector_o(vec),
    .irq_ready_i(rdy), .eoi_i(eoi));

  always #10 clk = ~clk;

  task automatic tick(); @(posedge clk); @(negedge clk); endtask
  task automatic settle(); tick(); tick(); endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit m_req(input int i);
    return (i < N_HW) ? hw[i] : ((m_sw >> (i - N_HW)) & 1) != 0;
  endfunction

  task automatic m_win(output bit v, output int idx);
    int bp = 0;
    v = 0; idx = 0;
    for (int i = 0; i < N_SRC; i++)
      if (m_req(i) && m_prio[i] > m_cur && m_prio[i] > bp) begin
        bp = m_prio[i]; idx = i; v = 1;
      end
  endtask

  task automatic check_out(input string req);
    bit v; int idx;
    m_win(v, idx);
    check_eq({req, " valid"}, int'(vld), int'(v));
    if (v) check_eq({req, " vector"}, int'(vec), idx);
  endtask

  task automatic wr_reg(input int a, input int d);
    addr = ADDR_W'(a); wdata = DATA_W'(d); wr = 1;
    tick();
    wr = 0;
  endtask

  task automatic rd_reg(input int a, output int d);
    addr = ADDR_W'(a);
    #1 d = int'(rdata);
  endtask

  task automatic set_prio(input int s, input int p); wr_reg(4 + s, p); m_prio[s] = p; endtask
  task automatic set_cur(input int p); wr_reg(0, p); m_cur = p; endtask
  task automatic sw_set(input int m); wr_reg(1, m); m_sw = m_sw | m; endtask
  task automatic sw_clr(input int m); wr_reg(2, m); m_sw = m_sw & ~m; endtask

  task automatic check_cur(input string req);
    int r;
    rd_reg(0, r);
    check_eq({req, " level"}, r, m_cur);
  endtask

  task automatic m_push(input int g);
    if (m_cnt < DEPTH) begin m_stk[m_cnt] = m_cur; m_cnt++; end
    m_cur = g;
  endtask

  task automatic do_ack(input bit with_eoi, input bit with_wr, input int wv, input string req);
    bit v; int idx, g;
    m_win(v, idx);
    check_eq({req, " valid before ack"}, int'(vld), 1);
    check_eq({req, " vector before ack"}, int'(vec), idx);
    g = m_prio[idx];
    rdy = 1; eoi = with_eoi;
    if (with_wr) begin wr = 1; addr = '0; wdata = DATA_W'(wv); end
    tick();
    rdy = 0; eoi = 0; wr = 0;
    check_eq({req, " R7 valid after ack"}, int'(vld), 0);
    if (with_eoi && m_cnt > 0) m_cur = g;
    else m_push(g);
  endtask

  task automatic do_eoi();
    eoi = 1;
    tick();
    eoi = 0;
    if (m_cnt > 0) begin m_cnt--; m_cur = m_stk[m_cnt]; end
  endtask

  task automatic t_reset();
    int r;
    check_eq("R7 reset valid", int'(vld), 0);
    rd_reg(0, r); check_eq("R5 reset level", r, 0);
    rd_reg(4 + 3, r); check_eq("R2 reset priority", r, 0);
    rd_reg(1, r); check_eq("R6 reset software pending", r, 0);
  endtask

  task automatic t_order();
    int r;
    set_prio(3, 6); set_prio(7, 6); set_prio(5, 2);
    rd_reg(4 + 3, r); check_eq("R2 priority readback", r, 6);
    rd_reg(4 + 5, r); check_eq("R2 priority readback", r, 2);
    hw = 12'h0A8; settle();
    check_out("R4 tie lowest index");
    check_eq("R4 tie winner", int'(vec), 3);
    set_prio(7, 9); settle();
    check_out("R4 higher priority");
    check_eq("R1 hardware vector", int'(vec), 7);
    hw = '0; settle();
    check_out("R4 idle");
  endtask

  task automatic t_disable();
    set_prio(1, 0); hw = 12'h002; settle();
    check_out("R3 disabled source");
    check_eq("R3 disabled valid", int'(vld), 0);
    set_prio(1, 1); settle();
    check_out("R3 enabled source");
    set_prio(1, 0); settle();
    check_eq("R3 disabled again", int'(vld), 0);
    hw = '0; settle();
  endtask

  task automatic t_mask();
    set_prio(4, 5); set_prio(6, 6);
    hw = 12'h050;
    set_cur(6); settle();
    check_eq("R5 equal level masked", int'(vld), 0);
    set_cur(5); settle();
    check_out("R5 above level");
    set_cur(4); settle();
    check_out("R5 lower level");
    hw = 12'h010; settle();
    check_out("R5 remaining source");
    check_cur("R5");
    set_cur(0); hw = '0; settle();
    check_out("R5 cleared");
  endtask

  task automatic t_sw();
    int r;
    set_prio(N_HW + 2, 3); set_prio(N_HW + 5, 3);
    sw_set(8'h24); settle();
    rd_reg(1, r); check_eq("R6 pending after set", r, 8'h24);
    check_out("R6 software source");
    check_eq("R1 software vector", int'(vec), N_HW + 2);
    sw_clr(8'h04); settle();
    check_out("R6 after clear");
    rd_reg(1, r); check_eq("R6 pending after clear", r, 8'h20);
    sw_clr(0); settle();
    rd_reg(1, r); check_eq("R6 zero clear no effect", r, 8'h20);
    sw_set(0); settle();
    rd_reg(1, r); check_eq("R6 zero set no effect", r, 8'h20);
    sw_clr(8'h20); settle();
    check_eq("R6 all cleared", int'(vld), 0);
  endtask

  task automatic t_handshake();
    set_prio(2, 5);
    hw = 12'h004;
    #1 check_eq("R7 not yet registered", int'(vld), 0);
    tick();
    check_eq("R7 one edge latency", int'(vld), 1);
    check_eq("R7 vector", int'(vec), 2);
    hw = '0; tick();
    check_eq("R10 withdrawn request", int'(vld), 0);
    rdy = 1; tick(); rdy = 0;
    check_cur("R7 ready without valid");
    hw = 12'h004; settle();
    do_ack(0, 0, 0, "R7");
    check_cur("R7 level after ack");
    check_eq("R7 level value", m_cur, 5);
    do_eoi(); check_cur("R8 restore after eoi");
    hw = '0; settle();
  endtask

  task automatic t_nest();
    set_prio(2, 3); set_prio(8, 7);
    hw = 12'h004; settle();
    do_ack(0, 0, 0, "R8 first");
    check_cur("R8 first level");
    hw = 12'h104; settle();
    check_out("R9 preemption offered");
    check_eq("R9 preempting vector", int'(vec), 8);
    do_ack(0, 0, 0, "R9 nested");
    check_cur("R9 nested level");
    settle(); check_eq("R9 lower masked while nested", int'(vld), 0);
    hw = 12'h004;
    do_eoi(); settle();
    check_cur("R8 pop to 3");
    check_eq("R8 equal level masked", int'(vld), 0);
    do_eoi(); settle();
    check_cur("R8 pop to 0");
    check_out("R8 pending offered again");
    hw = '0; settle();
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 5; k++) set_prio(k, k + 1);
    for (int k = 0; k < 5; k++) begin
      hw = N_HW'(1 << k); settle();
      do_ack(0, 0, 0, "R8 fill");
    end
    hw = '0;
    check_cur("R8 full level");
    do_eoi(); check_cur("R8 dropped level skipped");
    check_eq("R8 after drop", m_cur, 3);
    do_eoi(); check_cur("R8 pop");
    do_eoi(); check_cur("R8 pop");
    do_eoi(); check_cur("R8 pop to empty");
    do_eoi(); check_cur("R8 empty pop ignored");
    check_eq("R8 empty level", m_cur, 0);
    for (int k = 0; k < 5; k++) set_prio(k, 0);
    settle();
  endtask

  task automatic t_same_cycle();
    set_prio(2, 4); set_prio(8, 6);
    hw = 12'h004; settle();
    do_ack(0, 0, 0, "R11 setup");
    hw = 12'h104; settle();
    do_ack(1, 0, 0, "R11 ack with eoi");
    check_cur("R11 ack with eoi");
    do_eoi(); check_cur("R11 stack kept");
    check_eq("R11 restored level", m_cur, 0);
    settle();
    do_ack(0, 1, 2, "R11 ack with write");
    check_cur("R11 write lost");
    check_eq("R11 level", m_cur, 6);
    do_eoi(); hw = '0; settle();
    check_cur("R11 cleanup");
    set_prio(2, 0); set_prio(8, 0); settle();
  endtask

  task automatic t_random();
    bit v; int idx;
    for (int s = 0; s < N_SRC; s++) set_prio(s, int'($urandom_range(0, 15)));
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 9))
        0: set_prio(int'($urandom_range(0, N_SRC - 1)), int'($urandom_range(0, 15)));
        1: set_cur(int'($urandom_range(0, 15)));
        2, 3: hw = N_HW'($urandom);
        4: sw_set(int'($urandom_range(0, 255)));
        5: sw_clr(int'($urandom_range(0, 255)));
        6, 7: begin m_win(v, idx); if (v) do_ack(0, 0, 0, "R9 random"); end
        default: do_eoi();
      endcase
      settle();
      check_out("R4 R5 random");
    end
    check_cur("R8 random level");
  endtask

  initial begin
    for (int s = 0; s < N_SRC; s++) m_prio[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_disable();
    t_mask();
    t_sw();
    t_handshake();
    t_nest();
    t_overflow();
    t_same_cycle();
    t_random();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule